// File: doc/BRIEF.md
# Supervisor Power Mode Controller with Wake Handling

This block tracks the operating mode of a system supervisor. There are five modes: Normal, Stop, Sleep, Restart and Fail-Safe. Software moves the block between modes with a two-bit request on a parallel port. Bus and local wake events move it out of the low-power modes. A critical-failure input forces Fail-Safe from any mode. What a wake does depends on the mode it arrives in. In Normal and Stop the mode is kept and an interrupt is raised. In Sleep and Fail-Safe the block passes through Restart without raising an interrupt. Restart hands over to Normal only after a modelled regulator ramp has run out and a restart-delay strobe arrives.

Every enabled wake source sets its own sticky status bit. A bus wake also pulls an active-low receive indication low, so the host sees it even while no interrupt is raised. Software reads the status to clear the sticky bits. It can release the receive indication either by that read or by re-arming the transceiver. An optional configuration bit forces the watchdog on when a bus wake arrives in Stop. A Sleep request is refused, and flagged, when no wake source is enabled.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the outputs are: mode = 0 (Normal), int_n = 1, rx_wake_n = 1, vreg_en = 1, wake_stat = 0, wd_force = 0 and sleep_nak = 0. Mode codes are 0 Normal, 1 Sleep, 2 Stop, 3 Restart and 4 Fail-Safe.
- R2: A request with req_valid = 1 is accepted only in Normal or Stop. The req_mode encoding is 00 Normal, 01 Sleep, 10 Stop and 11 soft reset (to Restart). The new mode shows one cycle after the request.
- R3: An enabled wake in Normal or Stop leaves the mode unchanged and drives int_n low in the next cycle. Stop never goes to Normal unless a Normal request is made.
- R4: An enabled wake in Sleep or Fail-Safe moves the block to Restart with vreg_en = 1, and it leaves int_n unchanged. vreg_en is 0 only in Sleep and Fail-Safe.
- R5: Restart holds while wakes arrive and raises no interrupt. It moves to Normal on the first rst_dly_done pulse that comes after RAMP_CYC cycles spent in Restart. An earlier pulse is ignored.
- R6: An enabled bus wake in Stop sets wd_force when wd_cfg = 1. It does not set it when wd_cfg = 0. An accepted request clears wd_force.
- R7: Bit 0 of wake_stat is the bus wake and bit i+1 is local_wake[i]. A bit is set only when its wake_en bit is 1. A disabled source has no effect at all. The bits are sticky and are cleared by stat_rd. A wake in the same cycle as stat_rd leaves its bit set.
- R8: A Sleep request while wake_en is all zero keeps the mode and sets sleep_nak. stat_rd clears sleep_nak.
- R9: An enabled bus wake drives rx_wake_n low in the next cycle in any mode. rx_wake_n returns high on stat_rd or rx_rearm. int_n returns high on stat_rd.
- R10: crit_fail moves any mode to Fail-Safe in the next cycle. Requests are ignored in Sleep, Restart and Fail-Safe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Software mode request strobe |
| req_mode | input | 2 | Requested mode code |
| bus_wake | input | 1 | Bus wake event |
| local_wake | input | N_LOCAL | Local wake events |
| wake_en | input | N_LOCAL+1 | Per-source wake enable, bit 0 bus |
| wd_cfg | input | 1 | Force watchdog on after bus wake in Stop |
| crit_fail | input | 1 | Critical failure, enter Fail-Safe |
| rst_dly_done | input | 1 | Restart delay expired strobe |
| stat_rd | input | 1 | Status read, clears sticky flags |
| rx_rearm | input | 1 | Transceiver re-arm, releases rx_wake_n |
| mode | output | 3 | Current mode code |
| int_n | output | 1 | Active-low interrupt |
| rx_wake_n | output | 1 | Active-low receive wake indication |
| vreg_en | output | 1 | Main regulator enable |
| wake_stat | output | N_LOCAL+1 | Sticky wake source bits |
| wd_force | output | 1 | Watchdog enable override |
| sleep_nak | output | 1 | Sleep request refused flag |

## Verification
Two functions can fall in the same cycle: a status read that clears the sticky flags, and a new bus wake that sets them. The bench drives stat_rd and bus_wake in the same cycle. It passes only if the wake bit stays set and rx_wake_n and int_n stay low, because a set must win over a clear. The bench also puts a Normal request in the same cycle as the status read in Stop. It then judges that the request is taken and the pending interrupt is released.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    PM_NORMAL   = 3'd0,
    PM_SLEEP    = 3'd1,
    PM_STOP     = 3'd2,
    PM_RESTART  = 3'd3,
    PM_FAILSAFE = 3'd4
  } pm_mode_e;

  localparam logic [1:0] RQ_NORMAL  = 2'b00;
  localparam logic [1:0] RQ_SLEEP   = 2'b01;
  localparam logic [1:0] RQ_STOP    = 2'b10;
  localparam logic [1:0] RQ_SOFTRST = 2'b11;
endpackage

// File: rtl/pmc_ramp_timer.sv
module pmc_ramp_timer #(
  parameter int RAMP_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(RAMP_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RAMP_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LIMIT) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == LIMIT);
endmodule

// File: rtl/pmc_flag_bank.sv
module pmc_flag_bank #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hit,
  input  logic            stat_rd,
  input  logic            rx_rearm,
  input  logic            int_set,
  input  logic            nak_set,
  output logic [NSRC-1:0] stat_q,
  output logic            int_q,
  output logic            rx_q,
  output logic            nak_q
);
  for (genvar g = 0; g < NSRC; g++) begin : g_sticky
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bit_q <= 1'b0;
      else if (hit[g])  bit_q <= 1'b1;
      else if (stat_rd) bit_q <= 1'b0;
    end
    assign stat_q[g] = bit_q;
  end

  logic rx_clr;
  assign rx_clr = stat_rd || rx_rearm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= 1'b0;
      rx_q  <= 1'b0;
      nak_q <= 1'b0;
    end else begin
      if (int_set)      int_q <= 1'b1;
      else if (stat_rd) int_q <= 1'b0;
      if (hit[0])       rx_q  <= 1'b1;
      else if (rx_clr)  rx_q  <= 1'b0;
      if (nak_set)      nak_q <= 1'b1;
      else if (stat_rd) nak_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_mode,
  input  logic [NSRC-1:0] wake_hit,
  input  logic [NSRC-1:0] wake_en,
  input  logic            crit_fail,
  input  logic            ramp_done,
  input  logic            rst_dly_done,
  input  logic            wd_cfg,
  output pm_mode_e        mode_q,
  output logic            sleep_refused,
  output logic            int_set,
  output logic            wd_force_q
);
  pm_mode_e mode_d;
  logic     any_wake, awake_mode, req_ok, req_take, wd_d;

  always_comb begin
    any_wake      = |wake_hit;
    awake_mode    = (mode_q == PM_NORMAL) || (mode_q == PM_STOP);
    req_ok        = req_valid && awake_mode && !crit_fail;
    sleep_refused = req_ok && (req_mode == RQ_SLEEP) && (wake_en == '0);
    req_take      = req_ok && !sleep_refused;
    int_set       = any_wake && awake_mode;

    mode_d = mode_q;
    if (crit_fail) begin
      mode_d = PM_FAILSAFE;
    end else begin
      case (mode_q)
        PM_NORMAL, PM_STOP: begin
          if (req_take) begin
            case (req_mode)
              RQ_NORMAL: mode_d = PM_NORMAL;
              RQ_SLEEP:  mode_d = PM_SLEEP;
              RQ_STOP:   mode_d = PM_STOP;
              default:   mode_d = PM_RESTART;
            endcase
          end
        end
        PM_SLEEP, PM_FAILSAFE: if (any_wake) mode_d = PM_RESTART;
        PM_RESTART:            if (ramp_done && rst_dly_done) mode_d = PM_NORMAL;
        default:               mode_d = PM_NORMAL;
      endcase
    end

    wd_d = wd_force_q;
    if (req_take) wd_d = 1'b0;
    if (wake_hit[0] && (mode_q == PM_STOP) && wd_cfg) wd_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= PM_NORMAL;
      wd_force_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      wd_force_q <= wd_d;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int N_LOCAL  = 2,
  parameter int RAMP_CYC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_mode,
  input  logic               bus_wake,
  input  logic [N_LOCAL-1:0] local_wake,
  input  logic [N_LOCAL:0]   wake_en,
  input  logic               wd_cfg,
  input  logic               crit_fail,
  input  logic               rst_dly_done,
  input  logic               stat_rd,
  input  logic               rx_rearm,
  output logic [2:0]         mode,
  output logic               int_n,
  output logic               rx_wake_n,
  output logic               vreg_en,
  output logic [N_LOCAL:0]   wake_stat,
  output logic               wd_force,
  output logic               sleep_nak
);
  localparam int NSRC = N_LOCAL + 1;

  logic [1:0] rst_sh;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_int_n = rst_sh[1];

  logic [NSRC-1:0] wake_hit;
  pm_mode_e        mode_q;
  logic            ramp_done, sleep_refused, int_set, int_q, rx_q;

  assign wake_hit = {local_wake, bus_wake} & wake_en;

  pmc_ramp_timer #(.RAMP_CYC(RAMP_CYC)) u_ramp (
    .clk  (clk),
    .rst_n(rst_int_n),
    .run  (mode_q == PM_RESTART),
    .done (ramp_done)
  );

  pmc_mode_fsm #(.NSRC(NSRC)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .req_valid    (req_valid),
    .req_mode     (req_mode),
    .wake_hit     (wake_hit),
    .wake_en      (wake_en),
    .crit_fail    (crit_fail),
    .ramp_done    (ramp_done),
    .rst_dly_done (rst_dly_done),
    .wd_cfg       (wd_cfg),
    .mode_q       (mode_q),
    .sleep_refused(sleep_refused),
    .int_set      (int_set),
    .wd_force_q   (wd_force)
  );

  pmc_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .hit     (wake_hit),
    .stat_rd (stat_rd),
    .rx_rearm(rx_rearm),
    .int_set (int_set),
    .nak_set (sleep_refused),
    .stat_q  (wake_stat),
    .int_q   (int_q),
    .rx_q    (rx_q),
    .nak_q   (sleep_nak)
  );

  assign mode      = mode_q;
  assign int_n     = !int_q;
  assign rx_wake_n = !rx_q;
  assign vreg_en   = (mode_q != PM_SLEEP) && (mode_q != PM_FAILSAFE);
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int N_LOCAL = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_mode,
  input logic               bus_wake,
  input logic [N_LOCAL-1:0] local_wake,
  input logic [N_LOCAL:0]   wake_en,
  input logic               crit_fail,
  input logic               rst_dly_done,
  input logic               stat_rd,
  input logic [2:0]         mode,
  input logic               int_n,
  input logic               rx_wake_n,
  input logic               vreg_en,
  input logic [N_LOCAL:0]   wake_stat,
  input logic               sleep_nak
);
  logic any_hit, bus_hit;
  assign bus_hit = bus_wake && wake_en[0];
  assign any_hit = bus_hit || (|(local_wake & wake_en[N_LOCAL:1]));

  // R3
  stop_no_self_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && !(req_valid && req_mode == 2'b00)) |=> (mode != 3'd0));

  // R4
  sleep_wake_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && any_hit && !crit_fail) |=> (mode == 3'd3 && vreg_en));

  // R4
  sleep_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && !stat_rd) |=> $stable(int_n));

  // R5
  restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && !rst_dly_done && !crit_fail) |=> (mode == 3'd3));

  // R7
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((wake_stat & $past(wake_stat)) == $past(wake_stat)));

  // R8
  sleep_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'b01 && wake_en == '0 && !crit_fail &&
     (mode == 3'd0 || mode == 3'd2)) |=> (sleep_nak && $stable(mode)));

  // R9
  rx_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hit |=> !rx_wake_n);

  // R10
  failsafe_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crit_fail |=> (mode == 3'd4 && !vreg_en));
endmodule

bind pwr_mode_ctrl pmc_checker #(.N_LOCAL(N_LOCAL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .req_valid   (req_valid),
  .req_mode    (req_mode),
  .bus_wake    (bus_wake),
  .local_wake  (local_wake),
  .wake_en     (wake_en),
  .crit_fail   (crit_fail),
  .rst_dly_done(rst_dly_done),
  .stat_rd     (stat_rd),
  .mode        (mode),
  .int_n       (int_n),
  .rx_wake_n   (rx_wake_n),
  .vreg_en     (vreg_en),
  .wake_stat   (wake_stat),
  .sleep_nak   (sleep_nak)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, req_valid, bus_wake, wd_cfg, crit_fail, rst_dly_done, stat_rd, rx_rearm;
  logic [1:0] req_mode, local_wake;
  logic [2:0] wake_en, mode, wake_stat;
  logic       int_n, rx_wake_n, vreg_en, wd_force, sleep_nak;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.N_LOCAL(2), .RAMP_CYC(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .bus_wake(bus_wake), .local_wake(local_wake), .wake_en(wake_en), .wd_cfg(wd_cfg),
    .crit_fail(crit_fail), .rst_dly_done(rst_dly_done), .stat_rd(stat_rd),
    .rx_rearm(rx_rearm), .mode(mode), .int_n(int_n), .rx_wake_n(rx_wake_n),
    .vreg_en(vreg_en), .wake_stat(wake_stat), .wd_force(wd_force), .sleep_nak(sleep_nak));

  // vector: [11] req_valid [10:9] req_mode [8] bus [7:6] local [5] stat_rd
  //         [4:2] expected mode [1] expected int_n [0] expected rx_wake_n
  localparam int NV = 11;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 2'b10, 1'b0, 2'b00, 1'b0, 3'd2, 1'b1, 1'b1},
    {1'b0, 2'b00, 1'b1, 2'b00, 1'b0, 3'd2, 1'b0, 1'b0},
    {1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 3'd2, 1'b1, 1'b1},
    {1'b0, 2'b00, 1'b0, 2'b01, 1'b0, 3'd2, 1'b0, 1'b1},
    {1'b1, 2'b00, 1'b0, 2'b00, 1'b1, 3'd0, 1'b1, 1'b1},
    {1'b0, 2'b00, 1'b0, 2'b10, 1'b0, 3'd0, 1'b0, 1'b1},
    {1'b0, 2'b00, 1'b0, 2'b00, 1'b1, 3'd0, 1'b1, 1'b1},
    {1'b1, 2'b01, 1'b0, 2'b00, 1'b0, 3'd1, 1'b1, 1'b1},
    {1'b1, 2'b00, 1'b0, 2'b00, 1'b0, 3'd1, 1'b1, 1'b1},
    {1'b0, 2'b00, 1'b1, 2'b00, 1'b0, 3'd3, 1'b1, 1'b0},
    {1'b0, 2'b00, 1'b0, 2'b00, 1'b0, 3'd3, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 0; req_mode = 2'b00; bus_wake = 0; local_wake = 2'b00;
    stat_rd = 0; rx_rearm = 0; crit_fail = 0; rst_dly_done = 0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; wake_en = 3'b111; wd_cfg = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) step();
    chk("R1 mode", mode, 3'd0);
    chk("R1 int_n", int_n, 1'b1);
    chk("R1 rx_wake_n", rx_wake_n, 1'b1);
    chk("R1 vreg_en", vreg_en, 1'b1);
    chk("R1 wake_stat", wake_stat, 3'b000);
    chk("R1 wd_force", wd_force, 1'b0);
    chk("R1 sleep_nak", sleep_nak, 1'b0);

    // table walk: R2 R3 R4 R9
    for (int i = 0; i < NV; i++) begin
      req_valid  = VEC[i][11];
      req_mode   = VEC[i][10:9];
      bus_wake   = VEC[i][8];
      local_wake = VEC[i][7:6];
      stat_rd    = VEC[i][5];
      step();
      idle();
      chk($sformatf("R2/R3/R4 row %0d mode", i), mode, VEC[i][4:2]);
      chk($sformatf("R3/R9 row %0d int_n", i), int_n, VEC[i][1]);
      chk($sformatf("R9 row %0d rx_wake_n", i), rx_wake_n, VEC[i][0]);
      chk($sformatf("R4 row %0d vreg_en", i), vreg_en,
          (VEC[i][4:2] != 3'd1) && (VEC[i][4:2] != 3'd4));
    end

    // R5: early strobe ignored, then release after ramp
    rst_dly_done = 1; step(); idle();
    chk("R5 early strobe ignored", mode, 3'd3);
    repeat (6) step();
    chk("R5 hold without strobe", mode, 3'd3);
    rst_dly_done = 1; step(); idle();
    chk("R5 restart to normal", mode, 3'd0);

    // R7 / R9: sticky bit, rearm releases rx only, read clears
    chk("R7 bus bit set", wake_stat, 3'b001);
    rx_rearm = 1; step(); idle();
    chk("R9 rearm releases rx", rx_wake_n, 1'b1);
    chk("R7 sticky after rearm", wake_stat, 3'b001);
    stat_rd = 1; step(); idle();
    chk("R7 read clears", wake_stat, 3'b000);

    // R7: set and clear in the same cycle
    bus_wake = 1; stat_rd = 1; step(); idle();
    chk("R7 set wins stat", wake_stat, 3'b001);
    chk("R9 set wins rx", rx_wake_n, 1'b0);
    chk("R3 set wins int", int_n, 1'b0);
    stat_rd = 1; step(); idle();
    chk("R9 read releases int", int_n, 1'b1);

    // R7: disabled source ignored
    wake_en = 3'b001; local_wake = 2'b01; step(); idle();
    chk("R7 disabled stat", wake_stat, 3'b000);
    chk("R7 disabled int", int_n, 1'b1);

    // R8: refused sleep
    wake_en = 3'b000; req_valid = 1; req_mode = 2'b01; step(); idle();
    chk("R8 mode kept", mode, 3'd0);
    chk("R8 nak set", sleep_nak, 1'b1);
    stat_rd = 1; step(); idle();
    chk("R8 nak cleared", sleep_nak, 1'b0);

    // R6: watchdog override
    wake_en = 3'b111; req_valid = 1; req_mode = 2'b10; step(); idle();
    bus_wake = 1; step(); idle();
    chk("R6 cfg off no force", wd_force, 1'b0);
    stat_rd = 1; step(); idle();
    wd_cfg = 1; bus_wake = 1; step(); idle();
    chk("R6 force set", wd_force, 1'b1);
    chk("R3 stop kept", mode, 3'd2);
    req_valid = 1; req_mode = 2'b00; stat_rd = 1; step(); idle();
    chk("R6 force cleared", wd_force, 1'b0);
    chk("R2 stop to normal", mode, 3'd0);

    // R10 / R4 / R5: fail-safe path
    crit_fail = 1; step(); idle();
    chk("R10 failsafe", mode, 3'd4);
    chk("R10 regulator off", vreg_en, 1'b0);
    req_valid = 1; req_mode = 2'b00; step(); idle();
    chk("R10 request ignored", mode, 3'd4);
    local_wake = 2'b10; step(); idle();
    chk("R4 failsafe to restart", mode, 3'd3);
    chk("R4 no irq", int_n, 1'b1);
    chk("R4 regulator on", vreg_en, 1'b1);
    local_wake = 2'b10; step(); idle();
    chk("R5 wake in restart mode", mode, 3'd3);
    chk("R5 wake in restart int", int_n, 1'b1);
    repeat (10) step();
    rst_dly_done = 1; step(); idle();
    chk("R5 failsafe path to normal", mode, 3'd0);
    req_valid = 1; req_mode = 2'b11; step(); idle();
    chk("R2 soft reset", mode, 3'd3);

    summary();
    $finish;
  end
endmodule